// File: doc/BRIEF.md
# Machine-Cycle Timebase and Reset Qualifier

This block divides the oscillator clock into a machine cycle of six states, each state split into two phases, so that one machine cycle spans twelve oscillator periods. The state and phase counters come out as registered outputs for the rest of the core to decode. The counters free-run from power-up and never stop, including while the core is held in reset.

The raw reset pin is asynchronous. It passes through a two-flop synchronizer and is looked at only once per machine cycle, in the second phase of the fifth state. The internal reset rises only when two successive such samples both see the pin high. It falls at the first sample that sees the pin low. The first high sample also starts a 19-period grace window. During that window the bus-strobe enable stays high, so address-latch and program-store activity carries on. After the window the enable drops.

A separate port-force output is a purely combinational path from the pin. Ports therefore go to their reset state at once, with or without a running clock. The output stays forced until the internal reset is released.

Top module: `mcyc_rst_sampler`

## Requirements
- R1: `mc_state` counts 0 to 5 (meaning the first to the sixth state) and wraps. `mc_phase` is 0 for the first phase and 1 for the second. Each state lasts two oscillator periods, so one machine cycle is exactly 12 periods. From power-up the counter is at state 0 phase 0, and it advances on every rising clock edge.
- R2: `port_force` is high whenever `rst_pin` is high, with no clock edge required.
- R3: The pin reaches the sampler through a two-flop synchronizer. It is sampled at the clock edge that ends state 4 phase 1. `int_rst` rises at the second consecutive sample that sees it high. A pin raised just after clock edge n is first seen by the sample edge s with s ≥ n+3.
- R4: If a high pin is seen by one sample and the next sample sees it low, `int_rst` never rises and `bus_run` stays high.
- R5: `bus_run` is high in normal operation. It falls exactly 19 oscillator periods (clock edges) after the first sample edge that sees the pin high, provided reset is still pending.
- R6: At the first sample edge that sees the pin low, `int_rst` falls and `bus_run` returns high on that same edge.
- R7: `port_force` stays high while `int_rst` is high, even after the pin has dropped.
- R8: The timebase keeps counting without disturbance while reset is asserted.
- R9: `int_rst` changes, and `bus_run` rises, only on the edge that ends state 4 phase 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_pin | input | 1 | Raw asynchronous active-high reset pin |
| mc_state | output | 3 | Current state, 0..5 |
| mc_phase | output | 1 | Current phase, 0 = first, 1 = second |
| int_rst | output | 1 | Qualified internal reset, registered |
| bus_run | output | 1 | High while bus strobes may keep running |
| port_force | output | 1 | Combinational port reset force |

## Verification
Two things can land on the same clock edge: the release of the internal reset and the restoration of the bus-strobe enable. Both must happen on the edge that ends state 4 phase 1. The bench provokes this by holding the pin long enough for the grace window to expire, then dropping it. It expects both changes at one computed edge number, queued in a fixed order. The bench also places the pin rise exactly on the latest edge that still reaches a given sample, and one edge later. This judges the synchronizer latency to the period.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam int unsigned MCR_STATES       = 6;
  localparam int unsigned MCR_PHASES       = 2;
  localparam int unsigned MCR_SAMPLE_STATE = 4;
  localparam int unsigned MCR_SAMPLE_PHASE = 1;
  localparam int unsigned MCR_SYNC_STAGES  = 2;
  localparam int unsigned MCR_CONFIRM      = 2;
  localparam int unsigned MCR_HOLD         = 19;
endpackage

// File: rtl/mcr_timebase.sv
module mcr_timebase #(
  parameter int unsigned STATES       = 6,
  parameter int unsigned PHASES       = 2,
  parameter int unsigned SAMPLE_STATE = 4,
  parameter int unsigned SAMPLE_PHASE = 1,
  localparam int unsigned ST_W = (STATES > 1) ? $clog2(STATES) : 1,
  localparam int unsigned PH_W = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic            clk,
  output logic [ST_W-1:0] state_q,
  output logic [PH_W-1:0] phase_q,
  output logic            sample_en
);
  localparam logic [ST_W-1:0] ST_LAST = ST_W'(STATES - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);
  localparam logic [ST_W-1:0] ST_SMP  = ST_W'(SAMPLE_STATE);
  localparam logic [PH_W-1:0] PH_SMP  = PH_W'(SAMPLE_PHASE);

  logic [ST_W-1:0] st = '0;
  logic [PH_W-1:0] ph = '0;

  // Free-running: no reset, it must keep counting while the core is held.
  always_ff @(posedge clk) begin
    if (ph == PH_LAST) begin
      ph <= '0;
      st <= (st == ST_LAST) ? '0 : st + 1'b1;
    end else begin
      ph <= ph + 1'b1;
    end
  end

  assign state_q   = st;
  assign phase_q   = ph;
  assign sample_en = (st == ST_SMP) && (ph == PH_SMP);
endmodule

// File: rtl/mcr_sync.sv
module mcr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain = '0;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) chain[0] <= d_async;
    end else begin : g_next
      always_ff @(posedge clk) chain[i] <= chain[i-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/mcr_qualify.sv
module mcr_qualify #(
  parameter int unsigned CONFIRM = 2,
  parameter int unsigned HOLD    = 19,
  localparam int unsigned CW = $clog2(CONFIRM + 1),
  localparam int unsigned HW = $clog2(HOLD + 1)
) (
  input  logic clk,
  input  logic sample_en,
  input  logic pin_sync,
  output logic int_rst,
  output logic bus_run
);
  localparam logic [CW-1:0] CONF_MAX  = CW'(CONFIRM);
  localparam logic [CW-1:0] CONF_LAST = CW'(CONFIRM - 1);
  localparam logic [HW-1:0] HOLD_LD   = HW'(HOLD);

  logic [CW-1:0] hi_cnt   = '0;
  logic [HW-1:0] hold_cnt = '0;
  logic          rst_q    = 1'b0;
  logic          run_q    = 1'b1;

  always_ff @(posedge clk) begin
    if (sample_en && !pin_sync) begin
      // First low sample: release everything on this edge.
      hi_cnt   <= '0;
      hold_cnt <= '0;
      rst_q    <= 1'b0;
      run_q    <= 1'b1;
    end else begin
      if (sample_en && hi_cnt == '0) begin
        hold_cnt <= HOLD_LD;
      end else if (hold_cnt != '0) begin
        hold_cnt <= hold_cnt - 1'b1;
        if (hold_cnt == HW'(1)) run_q <= 1'b0;
      end
      if (sample_en) begin
        if (hi_cnt != CONF_MAX) hi_cnt <= hi_cnt + 1'b1;
        if (hi_cnt >= CONF_LAST) rst_q <= 1'b1;
      end
    end
  end

  assign int_rst = rst_q;
  assign bus_run = run_q;
endmodule

// File: rtl/mcyc_rst_sampler.sv
module mcyc_rst_sampler
  import mcr_pkg::*;
#(
  parameter int unsigned STATES       = MCR_STATES,
  parameter int unsigned PHASES       = MCR_PHASES,
  parameter int unsigned SAMPLE_STATE = MCR_SAMPLE_STATE,
  parameter int unsigned SAMPLE_PHASE = MCR_SAMPLE_PHASE,
  parameter int unsigned SYNC_STAGES  = MCR_SYNC_STAGES,
  parameter int unsigned CONFIRM      = MCR_CONFIRM,
  parameter int unsigned HOLD         = MCR_HOLD,
  localparam int unsigned ST_W = (STATES > 1) ? $clog2(STATES) : 1,
  localparam int unsigned PH_W = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic            clk_osc,
  input  logic            rst_pin,
  output logic [ST_W-1:0] mc_state,
  output logic [PH_W-1:0] mc_phase,
  output logic            int_rst,
  output logic            bus_run,
  output logic            port_force
);
  logic sample_en;
  logic pin_sync;

  mcr_timebase #(
    .STATES(STATES), .PHASES(PHASES),
    .SAMPLE_STATE(SAMPLE_STATE), .SAMPLE_PHASE(SAMPLE_PHASE)
  ) u_tb (
    .clk(clk_osc), .state_q(mc_state), .phase_q(mc_phase), .sample_en(sample_en)
  );

  mcr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_osc), .d_async(rst_pin), .q_sync(pin_sync)
  );

  mcr_qualify #(.CONFIRM(CONFIRM), .HOLD(HOLD)) u_qual (
    .clk(clk_osc), .sample_en(sample_en), .pin_sync(pin_sync),
    .int_rst(int_rst), .bus_run(bus_run)
  );

  // Bypasses the synchronizer so ports react without a clock.
  assign port_force = rst_pin | int_rst;
endmodule

// File: rtl/mcyc_rst_sampler_chk.sv
module mcyc_rst_sampler_chk #(
  parameter int unsigned STATES       = 6,
  parameter int unsigned PHASES       = 2,
  parameter int unsigned SAMPLE_STATE = 4,
  parameter int unsigned SAMPLE_PHASE = 1,
  localparam int unsigned ST_W = (STATES > 1) ? $clog2(STATES) : 1,
  localparam int unsigned PH_W = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input logic            clk_osc,
  input logic            rst_pin,
  input logic [ST_W-1:0] mc_state,
  input logic [PH_W-1:0] mc_phase,
  input logic            int_rst,
  input logic            bus_run,
  input logic            port_force,
  input logic            pin_sync
);
  logic started = 1'b0;
  always_ff @(posedge clk_osc) started <= 1'b1;

  // R1 / R8: phase advance and state step
  p_phase_step_r1: assert property (@(posedge clk_osc) disable iff (!started)
    (mc_phase != PH_W'(PHASES - 1)) |=> (mc_phase == $past(mc_phase) + 1'b1) && $stable(mc_state));
  p_state_step_r8: assert property (@(posedge clk_osc) disable iff (!started)
    (mc_phase == PH_W'(PHASES - 1)) |=> (mc_phase == '0) &&
      (mc_state == (($past(mc_state) == ST_W'(STATES - 1)) ? '0 : $past(mc_state) + 1'b1)));

  // R9: reset output moves only in the sample slot
  p_rst_slot_r9: assert property (@(posedge clk_osc) disable iff (!started)
    (int_rst != $past(int_rst)) |-> ($past(mc_state) == ST_W'(SAMPLE_STATE)) &&
                                    ($past(mc_phase) == PH_W'(SAMPLE_PHASE)));
  p_run_slot_r9: assert property (@(posedge clk_osc) disable iff (!started)
    $rose(bus_run) |-> ($past(mc_state) == ST_W'(SAMPLE_STATE)) &&
                       ($past(mc_phase) == PH_W'(SAMPLE_PHASE)));

  // R3: a rise needs a high synchronized pin at the sample
  p_rise_seen_r3: assert property (@(posedge clk_osc) disable iff (!started)
    $rose(int_rst) |-> $past(pin_sync));

  // R6: release restores the strobes on the same edge
  p_release_r6: assert property (@(posedge clk_osc) disable iff (!started)
    $fell(int_rst) |-> bus_run);

  // R2 / R7: combinational port force
  always_comb begin
    if (rst_pin) p_pin_force_r2: assert (port_force);
    if (int_rst) p_hold_force_r7: assert (port_force);
  end
endmodule

bind mcyc_rst_sampler mcyc_rst_sampler_chk #(
  .STATES(STATES), .PHASES(PHASES),
  .SAMPLE_STATE(SAMPLE_STATE), .SAMPLE_PHASE(SAMPLE_PHASE)
) u_chk (
  .clk_osc(clk_osc), .rst_pin(rst_pin), .mc_state(mc_state), .mc_phase(mc_phase),
  .int_rst(int_rst), .bus_run(bus_run), .port_force(port_force), .pin_sync(pin_sync)
);

// File: tb/mcyc_rst_sampler_bench.sv
module mcyc_rst_sampler_bench;
  logic       clk = 1'b0;
  logic       rst_pin = 1'b0;
  logic [2:0] mc_state;
  logic [0:0] mc_phase;
  logic       int_rst, bus_run, port_force;

  always #10 clk = ~clk;  // 50 MHz

  mcyc_rst_sampler u_mcyc_rst_sampler (
    .clk_osc(clk), .rst_pin(rst_pin), .mc_state(mc_state), .mc_phase(mc_phase),
    .int_rst(int_rst), .bus_run(bus_run), .port_force(port_force)
  );

  int checks = 0;
  int errors = 0;
  int unsigned edge_n = 0;
  always @(posedge clk) edge_n <= edge_n + 1;

  typedef struct packed {
    logic        is_bus;   // 0 = int_rst, 1 = bus_run
    logic        val;
    int unsigned at_edge;
  } evt_t;
  evt_t exp_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", req, act, exp, edge_n);
    end
  endtask

  // Monitor: timebase every period, output changes against the queue.
  logic prev_rst = 1'b0, prev_run = 1'b1;
  task automatic match(input logic is_bus, input logic v);
    evt_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, is_bus ? "R4/R5 unexpected bus_run change" : "R3/R4 unexpected int_rst change",
            int'(v), int'(!v));
      return;
    end
    e = exp_q.pop_front();
    check(e.is_bus == is_bus && e.val == v,
          is_bus ? "R5/R6 bus_run event kind" : "R3/R6 int_rst event kind",
          int'({is_bus, v}), int'({e.is_bus, e.val}));
    check(e.at_edge == edge_n, is_bus ? "R5/R6 bus_run edge" : "R3/R6 int_rst edge",
          int'(edge_n), int'(e.at_edge));
  endtask

  always @(negedge clk) begin
    // R1, R8: state and phase follow edge count modulo 12
    check(mc_state == 3'((edge_n % 12) / 2) && mc_phase == 1'((edge_n % 12) % 2),
          "R1/R8 timebase", int'({mc_state, mc_phase}),
          int'({3'((edge_n % 12) / 2), 1'((edge_n % 12) % 2)}));
    if (int_rst != prev_rst) match(1'b0, int_rst);
    if (bus_run != prev_run) match(1'b1, bus_run);
    prev_rst = int_rst;
    prev_run = bus_run;
  end

  // Sample edges are those with edge number % 12 == 10.
  function automatic int unsigned next_sample(input int unsigned m);
    int unsigned s = m + 3;
    while (s % 12 != 10) s++;
    return s;
  endfunction

  task automatic wait_edge(input int unsigned n);
    while (edge_n < n) @(negedge clk);
  endtask

  task automatic wait_phase(input int unsigned r);
    @(negedge clk);
    while (edge_n % 12 != r) @(negedge clk);
  endtask

  // Full reset with pin rise right after an edge of residue r.
  task automatic full_reset(input int unsigned r, input string tag);
    int unsigned m, s, p, s2;
    wait_phase(r);
    m = edge_n;
    s = next_sample(m);
    rst_pin = 1'b1;
    #1;
    check(port_force == 1'b1, "R2 immediate force", int'(port_force), 1);
    exp_q.push_back('{1'b0, 1'b1, s + 12});
    exp_q.push_back('{1'b1, 1'b0, s + 19});
    p = s + 30;
    wait_edge(p);
    rst_pin = 1'b0;
    s2 = next_sample(p);
    #1;
    check(port_force == 1'b1, "R7 force held after pin drop", int'(port_force), 1);
    exp_q.push_back('{1'b0, 1'b0, s2});
    exp_q.push_back('{1'b1, 1'b1, s2});
    wait_edge(s2 + 2);
    check(exp_q.size() == 0, {"R3/R5/R6 events consumed ", tag}, exp_q.size(), 0);
    check(port_force == 1'b0 && int_rst == 1'b0 && bus_run == 1'b1,
          "R6 released state", int'({port_force, int_rst, bus_run}), 1);
  endtask

  initial begin
    @(negedge clk);
    check(int_rst == 1'b0, "R3 reset-state int_rst", int'(int_rst), 0);
    check(bus_run == 1'b1, "R5 reset-state bus_run", int'(bus_run), 1);
    check(port_force == 1'b0, "R2 reset-state port_force", int'(port_force), 0);

    full_reset(3, "mid-cycle");
    full_reset(7, "latest edge that still reaches the sample");  // s = m+3
    full_reset(8, "one edge too late");                           // s = m+14

    // R4: glitch seen by one sample only
    begin
      int unsigned m, s;
      wait_phase(5);
      m = edge_n;
      s = next_sample(m);
      rst_pin = 1'b1;
      #1;
      check(port_force == 1'b1, "R2 force on short pulse", int'(port_force), 1);
      wait_edge(s + 2);
      rst_pin = 1'b0;
      wait_edge(s + 30);
      check(int_rst == 1'b0, "R4 int_rst stayed low", int'(int_rst), 0);
      check(bus_run == 1'b1, "R4 bus_run stayed high", int'(bus_run), 1);
      check(exp_q.size() == 0, "R4 no pending events", exp_q.size(), 0);
    end

    wait_edge(edge_n + 4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (edge_n > 5000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected<5000", edge_n);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule